// File: doc/BRIEF.md
# Round-Robin Warp Fetch Scheduler

This block sits at the front of a multi-warp SIMT core. In each cycle it picks at most one warp to receive an instruction fetch. It searches the warps in rotating order, starting at the warp just after the one it picked last. A warp can be picked only if it is active and is not already waiting on an instruction in flight. Picking a warp marks it as held. The hold is lifted later by one of two release ports. The decode-stage port lifts it for ordinary instructions. The execute-completion port lifts it for instructions flagged as holding their warp until they finish.

The per-warp active mask is registered inside the block. Out of reset, warp 0 is the only active warp. The block also counts instructions between pick and commit, and it raises a running flag while that count is nonzero. Program counters, instruction memory and decoding belong to other blocks.

Top module: `wsched_top`

## Requirements
- R1: The search for a pick starts at the warp index one above the last picked index and wraps modulo NUM_WARPS. Each warp is considered at most once per cycle.
- R2: A warp is eligible when its registered active bit is 1 and its hold bit is 0. The first eligible warp in search order is reported on `sched_wid_o`, with `sched_vld_o` high, in the same cycle.
- R3: On a clock edge with `sched_vld_o` high, the picked warp's hold bit is set. The last-picked index becomes that warp, so the same warp is not picked in the following cycle.
- R4: With no eligible warp, `sched_vld_o` is 0 and the last-picked index keeps its value.
- R5: A decode release (`dec_vld_i`=1) with `dec_hold_i`=0 clears the hold bit of warp `dec_wid_i` at the next edge. With `dec_hold_i`=1 it has no effect.
- R6: An execute release (`exe_vld_i`=1) with `exe_hold_i`=1 clears the hold bit of warp `exe_wid_i` at the next edge. With `exe_hold_i`=0 it has no effect.
- R7: After reset the registered active mask is 1 for warp 0 only, all hold bits are 0, the last-picked index is 0 and `running_o` is 0. After that, the active mask loads `active_i` on every edge.
- R8: A new pick and a release for the same warp in the same cycle leave that warp held. A release for a different warp in that cycle still takes effect.
- R9: An in-flight count rises by one on each pick and falls by one on each `commit_i` pulse, and is unchanged when both occur together. `running_o` is high exactly while the count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| active_i | input | NUM_WARPS | Per-warp active mask, registered each cycle |
| dec_vld_i | input | 1 | Decode-stage release valid |
| dec_wid_i | input | WID_W | Warp index of the decode release |
| dec_hold_i | input | 1 | Instruction holds its warp until execution completes |
| exe_vld_i | input | 1 | Execute-completion release valid |
| exe_wid_i | input | WID_W | Warp index of the completing instruction |
| exe_hold_i | input | 1 | Completing instruction was flagged as warp-holding |
| commit_i | input | 1 | One instruction committed |
| sched_vld_o | output | 1 | A warp is picked this cycle |
| sched_wid_o | output | WID_W | Index of the picked warp |
| running_o | output | 1 | At least one instruction is in flight |

## Verification
The assertions assume that `commit_i` pulses only while `running_o` is high. They also assume that the number of instructions in flight never exceeds MAX_INFLIGHT. The stimulus honours both. The bench's reference model drives a commit only when its own in-flight count is nonzero, and it forces a commit whenever that count reaches eight. Releases may name any warp, held or not, and the hold flags are toggled freely. This exercises both release paths against each other and against same-cycle picks.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  function automatic int wrap_add(input int base, input int ofs, input int n);
    int s;
    s = base + ofs;
    while (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
  parameter int NUM_WARPS = 4,
  parameter int WID_W     = 2
) (
  input  logic [NUM_WARPS-1:0] elig_i,
  input  logic [WID_W-1:0]     last_i,
  output logic                 vld_o,
  output logic [WID_W-1:0]     wid_o
);
  always_comb begin
    vld_o = 1'b0;
    wid_o = '0;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      int idx;
      idx = wsched_pkg::wrap_add(int'(last_i), k, NUM_WARPS);
      if (!vld_o && elig_i[idx]) begin
        vld_o = 1'b1;
        wid_o = WID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/wsched_hold_mask.sv
module wsched_hold_mask #(
  parameter int NUM_WARPS = 4,
  parameter int WID_W     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_vld_i,
  input  logic [WID_W-1:0]     set_wid_i,
  input  logic                 clr_a_vld_i,
  input  logic [WID_W-1:0]     clr_a_wid_i,
  input  logic                 clr_b_vld_i,
  input  logic [WID_W-1:0]     clr_b_wid_i,
  output logic [NUM_WARPS-1:0] hold_o
);
  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_bit
    logic set_hit, clr_hit;
    assign set_hit = set_vld_i && (int'(set_wid_i) == g);
    assign clr_hit = (clr_a_vld_i && (int'(clr_a_wid_i) == g)) ||
                     (clr_b_vld_i && (int'(clr_b_wid_i) == g));
    // set has priority over any clear on the same warp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hold_o[g] <= 1'b0;
      else if (set_hit) hold_o[g] <= 1'b1;
      else if (clr_hit) hold_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/wsched_inflight.sv
module wsched_inflight #(
  parameter int MAX_INFLIGHT = 16,
  localparam int CNT_W = $clog2(MAX_INFLIGHT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic running_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i) cnt_q <= cnt_q + CNT_W'(1);
    else if (dec_i && !inc_i) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign running_o = (cnt_q != '0);
endmodule

// File: rtl/wsched_top.sv
module wsched_top #(
  parameter int NUM_WARPS    = 4,
  parameter int MAX_INFLIGHT = 16,
  localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WARPS-1:0] active_i,
  input  logic                 dec_vld_i,
  input  logic [WID_W-1:0]     dec_wid_i,
  input  logic                 dec_hold_i,
  input  logic                 exe_vld_i,
  input  logic [WID_W-1:0]     exe_wid_i,
  input  logic                 exe_hold_i,
  input  logic                 commit_i,
  output logic                 sched_vld_o,
  output logic [WID_W-1:0]     sched_wid_o,
  output logic                 running_o
);
  logic [NUM_WARPS-1:0] act_q;
  logic [NUM_WARPS-1:0] stall_q;
  logic [WID_W-1:0]     last_q;
  logic [NUM_WARPS-1:0] elig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= NUM_WARPS'(1);
    else         act_q <= active_i;
  end

  assign elig = act_q & ~stall_q;

  wsched_rr_pick #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_pick (
    .elig_i (elig),
    .last_i (last_q),
    .vld_o  (sched_vld_o),
    .wid_o  (sched_wid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          last_q <= '0;
    else if (sched_vld_o) last_q <= sched_wid_o;
  end

  wsched_hold_mask #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_vld_i   (sched_vld_o),
    .set_wid_i   (sched_wid_o),
    .clr_a_vld_i (dec_vld_i && !dec_hold_i),
    .clr_a_wid_i (dec_wid_i),
    .clr_b_vld_i (exe_vld_i && exe_hold_i),
    .clr_b_wid_i (exe_wid_i),
    .hold_o      (stall_q)
  );

  wsched_inflight #(.MAX_INFLIGHT(MAX_INFLIGHT)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (sched_vld_o),
    .dec_i     (commit_i),
    .running_o (running_o)
  );
endmodule

// File: rtl/wsched_chk.sv
module wsched_chk #(
  parameter int NUM_WARPS = 4,
  parameter int WID_W     = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sched_vld_o,
  input logic [WID_W-1:0]     sched_wid_o,
  input logic                 running_o,
  input logic                 commit_i,
  input logic                 dec_vld_i,
  input logic [WID_W-1:0]     dec_wid_i,
  input logic                 dec_hold_i,
  input logic [NUM_WARPS-1:0] act_q,
  input logic [NUM_WARPS-1:0] stall_q,
  input logic [WID_W-1:0]     last_q
);
  AST_PICK_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sched_vld_o |-> (act_q[sched_wid_o] && !stall_q[sched_wid_o])); // R2
  AST_NO_REPICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sched_vld_o |=> !(sched_vld_o && sched_wid_o == $past(sched_wid_o))); // R3
  AST_LAST_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sched_vld_o |=> (last_q == $past(sched_wid_o))); // R3
  AST_LAST_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sched_vld_o |=> $stable(last_q)); // R4
  AST_DEC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_vld_i && !dec_hold_i && !(sched_vld_o && sched_wid_o == dec_wid_i))
      |=> !stall_q[$past(dec_wid_i)]); // R5
  AST_PICK_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sched_vld_o |=> running_o); // R9
  AST_COMMIT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> running_o); // R9
endmodule

bind wsched_top wsched_chk #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sched_vld_o (sched_vld_o),
  .sched_wid_o (sched_wid_o),
  .running_o   (running_o),
  .commit_i    (commit_i),
  .dec_vld_i   (dec_vld_i),
  .dec_wid_i   (dec_wid_i),
  .dec_hold_i  (dec_hold_i),
  .act_q       (act_q),
  .stall_q     (stall_q),
  .last_q      (last_q)
);

// File: tb/sim_wsched_top.sv
`timescale 1ns/1ps
module sim_wsched_top;
  localparam int NW = 4;
  localparam int WW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NW-1:0] active_i = '0;
  logic          dec_vld_i = 1'b0, dec_hold_i = 1'b0;
  logic [WW-1:0] dec_wid_i = '0;
  logic          exe_vld_i = 1'b0, exe_hold_i = 1'b0;
  logic [WW-1:0] exe_wid_i = '0;
  logic          commit_i = 1'b0;
  logic          sched_vld_o, running_o;
  logic [WW-1:0] sched_wid_o;

  always #2 clk_i = ~clk_i;

  wsched_top #(.NUM_WARPS(NW), .MAX_INFLIGHT(16)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // reference model
  bit m_act[NW];
  bit m_hold[NW];
  int m_last, m_cnt;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NW; i++) begin m_act[i] = (i == 0); m_hold[i] = 0; end
    m_last = 0; m_cnt = 0;
  endtask

  // drive after negedge, compare, then advance model across the next posedge
  task automatic cyc(input string tag, input logic [NW-1:0] a,
                     input bit dv, input int dw, input bit dh,
                     input bit ev, input int ew, input bit eh, input bit cm);
    bit pv; int pw;
    bit c;
    @(negedge clk_i);
    c = cm && (m_cnt > 0);
    active_i = a; dec_vld_i = dv; dec_wid_i = WW'(dw); dec_hold_i = dh;
    exe_vld_i = ev; exe_wid_i = WW'(ew); exe_hold_i = eh; commit_i = c;
    #1;
    pv = 0; pw = 0;
    for (int k = 1; k <= NW; k++) begin
      int idx;
      idx = (m_last + k) % NW;
      if (!pv && m_act[idx] && !m_hold[idx]) begin pv = 1; pw = idx; end
    end
    check(tag, "sched_vld", int'(sched_vld_o), int'(pv));
    if (pv) check(tag, "sched_wid", int'(sched_wid_o), pw);
    check({tag, " R9"}, "running", int'(running_o), int'(m_cnt != 0));
    @(posedge clk_i);
    if (dv && !dh) m_hold[dw] = 0;
    if (ev && eh)  m_hold[ew] = 0;
    if (pv) begin m_hold[pw] = 1; m_last = pw; end
    m_cnt = m_cnt + int'(pv) - int'(c);
    for (int i = 0; i < NW; i++) m_act[i] = a[i];
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk_i);
    #1;
    check("R7", "reset sched_vld", int'(sched_vld_o), 1);
    check("R7", "reset sched_wid", int'(sched_wid_o), 0);
    check("R7", "reset running", int'(running_o), 0);
    rst_ni = 1'b1;
    // R7: warp 0 alone active out of reset
    cyc("R7", 4'h0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R4", 4'h0, 0, 0, 0, 0, 0, 0, 0);
    // R1 R3: all active, rotation then exhaustion
    for (int i = 0; i < 6; i++) cyc("R1 R3 R4", 4'hF, 0, 0, 0, 0, 0, 0, 0);
    // R5: flagged decode release ignored, plain one clears
    cyc("R5", 4'hF, 1, 2, 1, 0, 0, 0, 0);
    cyc("R5", 4'hF, 0, 0, 0, 0, 0, 0, 0);
    cyc("R5", 4'hF, 1, 2, 0, 0, 0, 0, 0);
    cyc("R5", 4'hF, 0, 0, 0, 0, 0, 0, 0);
    // R6: unflagged execute release ignored, flagged one clears
    cyc("R6", 4'hF, 0, 0, 0, 1, 1, 0, 0);
    cyc("R6", 4'hF, 0, 0, 0, 0, 0, 0, 0);
    cyc("R6", 4'hF, 0, 0, 0, 1, 1, 1, 0);
    cyc("R6", 4'hF, 0, 0, 0, 0, 0, 0, 0);
    // R8: release of warp being picked plus a different warp
    cyc("R8", 4'hF, 1, 3, 0, 0, 0, 0, 0);
    cyc("R8", 4'hF, 1, 3, 0, 1, 0, 1, 0);
    cyc("R8", 4'hF, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8", 4'hF, 0, 0, 0, 0, 0, 0, 0);
    // R9: drain
    for (int i = 0; i < 14; i++) cyc("R9", 4'h0, 0, 0, 0, 0, 0, 0, 1);
    // R2: random mix
    for (int i = 0; i < 400; i++) begin
      logic [NW-1:0] a; int r;
      a = NW'($urandom);
      r = $urandom;
      cyc("R1 R2 R5 R6 R8", a, r[0], r[3:2], r[4], r[5], r[7:6], r[8],
          r[9] || (m_cnt >= 8));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule